// File: doc/BRIEF.md
# Multi-Gate First-Photon Window Tracker

This block lets a photon-timing array open many short gate-on windows inside one frame instead of only one. Each window ends with its own global STOP event, whose 4-bit fine phase code is written into a shared table of up to 64 entries. Each pixel has a small gate counter. The counter advances every time a window closes and stops at the pixel's first photon. When the frame ends, the readout takes the pixel's gate index and uses it to fetch the matching STOP phase from the table. The result joins the pixel's own coarse and START fine bits to form a 16-bit time tag.

A frame-start strobe clears every counter, every hit flag, the table fill count and the overflow flag. Gate-open and gate-close strobes drive a single window state. Photon flags are sampled only while a window is open. Both read ports are combinational: a pixel-select input returns that pixel's gate index and valid flag, and a table-address input returns the stored phase.

Top module: `fpw_tracker`

## Requirements
- R1: When `frame_start` is high at a clock edge, the tracker clears all pixel counters and hit flags, `tbl_count` and `stop_overflow`, and closes the window. This takes priority over every other strobe in the same cycle, so a `stop_valid` in that cycle is not stored.
- R2: A `gate_open` while the window is closed opens it. The window is open from the cycle after that strobe up to and including the cycle in which an effective `gate_close` arrives. A `gate_open` while the window is open has no effect, and a `gate_close` while it is closed has no effect.
- R3: At each effective gate close, every pixel that has not yet seen a photon increments its gate counter by one. The counter saturates at 63.
- R4: The first `pix_hit` bit seen for a pixel while the window is open latches that pixel's valid flag. This includes the closing cycle, in which case the hit wins and that pixel's counter does not advance. From then until the next frame start the pixel's gate index is frozen, and later hits change nothing.
- R5: A `pix_hit` bit seen while the window is closed is ignored. This includes the cycle that carries the opening strobe.
- R6: A `stop_valid` while fewer than 64 entries are held writes `stop_phase` at table entry `tbl_count`, and `tbl_count` then increments by one.
- R7: A `stop_valid` while 64 entries are held is dropped and leaves the table unchanged. It sets `stop_overflow`, which stays high until the next frame start.
- R8: A pixel with no photon in the frame reports `pix_valid` = 0 and `pix_idx` = 0.
- R9: The reads are combinational. `pix_idx` and `pix_valid` follow `pix_sel`, and `tbl_data` follows `tbl_addr`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears all frame state (R1) |
| gate_open | input | 1 | Opens a gate-on window |
| gate_close | input | 1 | Closes the window |
| pix_hit | input | NUM_PIX | Per-pixel photon flags |
| stop_valid | input | 1 | Global STOP event strobe |
| stop_phase | input | PHASE_W | STOP fine phase code |
| pix_sel | input | $clog2(NUM_PIX) | Pixel read select |
| pix_idx | output | 6 | Gate index of selected pixel |
| pix_valid | output | 1 | Selected pixel saw a photon |
| tbl_addr | input | 6 | STOP table read address |
| tbl_data | output | PHASE_W | STOP phase at `tbl_addr` |
| tbl_count | output | 7 | Number of stored STOP entries |
| stop_overflow | output | 1 | A STOP was dropped this frame |

## Verification
Every strobe takes effect at the clock edge that samples it. Counters, hit flags, the fill count and the overflow flag therefore show their new value just after that one edge, and the read ports add no further delay. The bench drives its strobes at the falling edge and clears them 2 ns after the rising edge. It then compares every pixel and every valid table entry against a model built from the requirements. Because the strobes are clear, the idle edges that pass during these long compares change nothing. Window-state effects such as a hit in the opening cycle or a redundant close are checked at the first edge where they could have changed a pixel's index.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam int GATE_IDX_W   = 6;
    localparam int GATE_DEPTH   = 1 << GATE_IDX_W;
    localparam int PHASE_W_DEF  = 4;

    // Window control bundle shared by all pixel counters
    typedef struct packed {
        logic clear;     // frame start
        logic active;    // window open this cycle
        logic close_ev;  // effective close in this cycle
    } gate_ctl_t;

    function automatic logic [GATE_IDX_W-1:0] sat_inc(input logic [GATE_IDX_W-1:0] v);
        return (v == {GATE_IDX_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/fpw_gate_ctrl.sv
module fpw_gate_ctrl
    import fpw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_start,
    input  logic      gate_open,
    input  logic      gate_close,
    output gate_ctl_t ctl
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            open_q <= 1'b0;
        end else if (!open_q && gate_open) begin
            open_q <= 1'b1;
        end else if (open_q && gate_close) begin
            open_q <= 1'b0;
        end
    end

    always_comb begin
        ctl.clear    = frame_start;
        ctl.active   = open_q && !frame_start;
        ctl.close_ev = open_q && gate_close && !frame_start;
    end
endmodule

// File: rtl/fpw_pix_counter.sv
module fpw_pix_counter
    import fpw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  gate_ctl_t             ctl,
    input  logic                  hit,
    output logic [GATE_IDX_W-1:0] idx,
    output logic                  seen
);
    logic [GATE_IDX_W-1:0] cnt_q;
    logic                  seen_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (!seen_q) begin
            if (ctl.active && hit) begin
                seen_q <= 1'b1;
            end else if (ctl.close_ev) begin
                cnt_q <= sat_inc(cnt_q);
            end
        end
    end

    assign idx  = seen_q ? cnt_q : '0;
    assign seen = seen_q;
endmodule

// File: rtl/fpw_stop_table.sv
module fpw_stop_table #(
    parameter int DEPTH   = 64,
    parameter int PHASE_W = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_phase,
    input  logic [AW-1:0]      rd_addr,
    output logic [PHASE_W-1:0] rd_data,
    output logic [CW-1:0]      count,
    output logic               overflow
);
    logic [PHASE_W-1:0] mem [DEPTH];
    logic [CW-1:0]      cnt_q;
    logic               ovf_q;
    logic               full;

    assign full = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && wr_en && !full) begin
            mem[cnt_q[AW-1:0]] <= wr_phase;
        end
    end

    assign rd_data  = mem[rd_addr];
    assign count    = cnt_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/fpw_tracker.sv
module fpw_tracker
    import fpw_pkg::*;
#(
    parameter int NUM_PIX  = 16,
    parameter int PHASE_W  = PHASE_W_DEF,
    localparam int SEL_W   = $clog2(NUM_PIX),
    localparam int CW      = $clog2(GATE_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_start,
    input  logic                  gate_open,
    input  logic                  gate_close,
    input  logic [NUM_PIX-1:0]    pix_hit,
    input  logic                  stop_valid,
    input  logic [PHASE_W-1:0]    stop_phase,
    input  logic [SEL_W-1:0]      pix_sel,
    output logic [GATE_IDX_W-1:0] pix_idx,
    output logic                  pix_valid,
    input  logic [GATE_IDX_W-1:0] tbl_addr,
    output logic [PHASE_W-1:0]    tbl_data,
    output logic [CW-1:0]         tbl_count,
    output logic                  stop_overflow
);
    gate_ctl_t             ctl;
    logic [GATE_IDX_W-1:0] idx_arr [NUM_PIX];
    logic [NUM_PIX-1:0]    seen_vec;

    fpw_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .gate_open  (gate_open),
        .gate_close (gate_close),
        .ctl        (ctl)
    );

    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        fpw_pix_counter u_cnt (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .hit (pix_hit[p]),
            .idx (idx_arr[p]),
            .seen(seen_vec[p])
        );
    end

    fpw_stop_table #(
        .DEPTH  (GATE_DEPTH),
        .PHASE_W(PHASE_W)
    ) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_start),
        .wr_en   (stop_valid),
        .wr_phase(stop_phase),
        .rd_addr (tbl_addr),
        .rd_data (tbl_data),
        .count   (tbl_count),
        .overflow(stop_overflow)
    );

    assign pix_idx   = idx_arr[pix_sel];
    assign pix_valid = seen_vec[pix_sel];
endmodule

// File: rtl/fpw_tracker_chk.sv
module fpw_tracker_chk #(
    parameter int NUM_PIX = 16,
    parameter int PHASE_W = 4,
    localparam int SEL_W  = $clog2(NUM_PIX),
    localparam int DEPTH  = 64,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic               stop_valid,
    input logic [SEL_W-1:0]   pix_sel,
    input logic [5:0]         pix_idx,
    input logic               pix_valid,
    input logic [CW-1:0]      tbl_count,
    input logic               stop_overflow
);
    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (tbl_count == '0) && !stop_overflow && !pix_valid); // R1

    AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ($past(pix_valid) && !$past(frame_start) && !$past(rst) && $stable(pix_sel))
        |-> (pix_valid && $stable(pix_idx))); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (stop_valid && !frame_start && tbl_count < CW'(DEPTH))
        |=> (tbl_count == $past(tbl_count) + CW'(1))); // R6

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        tbl_count <= CW'(DEPTH)); // R6

    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (stop_valid && !frame_start && tbl_count == CW'(DEPTH))
        |=> (stop_overflow && tbl_count == CW'(DEPTH))); // R7

    AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stop_overflow && !frame_start) |=> stop_overflow); // R7

    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix_idx == '0)); // R8
endmodule

bind fpw_tracker fpw_tracker_chk #(
    .NUM_PIX(NUM_PIX),
    .PHASE_W(PHASE_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .stop_valid   (stop_valid),
    .pix_sel      (pix_sel),
    .pix_idx      (pix_idx),
    .pix_valid    (pix_valid),
    .tbl_count    (tbl_count),
    .stop_overflow(stop_overflow)
);

// File: tb/fpw_tracker_test.sv
`timescale 1ns/1ps
module fpw_tracker_test;
    localparam int NP = 8;
    localparam int VW = 23;
    localparam int NV = 14;

    // {frame, open, close, stop, phase[3:0], hit[7:0], expected count[6:0]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 7'd0},  // R1 frame start
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 7'd0},  // R2 open
        {1'b0, 1'b0, 1'b0, 1'b1, 4'h5, 8'h01, 7'd1},  // R4 p0 in gate 0, R6 stop
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h02, 7'd1},  // R4 p1 on closing cycle
        {1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h04, 7'd1},  // R5 p2 while closed
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 7'd1},  // R2 redundant close
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h08, 7'd1},  // R5 hit in opening cycle
        {1'b0, 1'b0, 1'b0, 1'b1, 4'h9, 8'h08, 7'd2},  // R4 p3 gate 1
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 7'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 7'd2},
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h21, 7'd2},  // R4 p0 again ignored, p5 gate 2
        {1'b0, 1'b0, 1'b0, 1'b1, 4'hC, 8'h00, 7'd3},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 8'h00, 7'd3},  // R2 close while closed ignored
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h80, 7'd3}   // R3 p7 gate 3
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0, gate_open = 1'b0, gate_close = 1'b0;
    logic [NP-1:0] pix_hit = '0;
    logic          stop_valid = 1'b0;
    logic [3:0]    stop_phase = '0;
    logic [2:0]    pix_sel = '0;
    logic [5:0]    pix_idx;
    logic          pix_valid;
    logic [5:0]    tbl_addr = '0;
    logic [3:0]    tbl_data;
    logic [6:0]    tbl_count;
    logic          stop_overflow;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // requirement-level model
    bit       m_act;
    bit       m_seen [NP];
    int       m_cnt  [NP];
    int       m_fill;
    bit       m_ovf;
    int       m_tab  [64];

    always #10 clk = ~clk;

    fpw_tracker #(.NUM_PIX(NP), .PHASE_W(4)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .gate_open(gate_open), .gate_close(gate_close), .pix_hit(pix_hit),
        .stop_valid(stop_valid), .stop_phase(stop_phase), .pix_sel(pix_sel),
        .pix_idx(pix_idx), .pix_valid(pix_valid), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .tbl_count(tbl_count), .stop_overflow(stop_overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_act = 0; m_fill = 0; m_ovf = 0;
        for (int p = 0; p < NP; p++) begin m_seen[p] = 0; m_cnt[p] = 0; end
    endtask

    task automatic step(input bit fs, input bit op, input bit cl, input bit sv,
                        input logic [3:0] ph, input logic [NP-1:0] hit);
        @(negedge clk);
        frame_start = fs; gate_open = op; gate_close = cl;
        stop_valid = sv; stop_phase = ph; pix_hit = hit;
        @(posedge clk);
        if (fs) model_clear();
        else begin
            for (int p = 0; p < NP; p++) begin
                if (!m_seen[p]) begin
                    if (m_act && hit[p]) m_seen[p] = 1;
                    else if (m_act && cl && m_cnt[p] < 63) m_cnt[p]++;
                end
            end
            if (sv) begin
                if (m_fill < 64) begin m_tab[m_fill] = ph; m_fill++; end
                else m_ovf = 1;
            end
            if (!m_act && op) m_act = 1;
            else if (m_act && cl) m_act = 0;
        end
        #2;
        frame_start = 0; gate_open = 0; gate_close = 0;
        stop_valid = 0; pix_hit = '0;
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            pix_sel = 3'(p);
            #1;
            chk(pix_valid == m_seen[p], "R4/R8 pix_valid", pix_valid, m_seen[p]);
            chk(pix_idx == (m_seen[p] ? m_cnt[p] : 0), "R3/R4/R8 pix_idx",
                pix_idx, m_seen[p] ? m_cnt[p] : 0);
        end
        for (int a = 0; a < m_fill; a++) begin
            tbl_addr = 6'(a);
            #1;
            chk(tbl_data == m_tab[a], "R6/R9 tbl_data", tbl_data, m_tab[a]);
        end
        chk(tbl_count == m_fill, "R6 tbl_count", tbl_count, m_fill);
        chk(stop_overflow == m_ovf, "R7 stop_overflow", stop_overflow, m_ovf);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        #1;
        chk(tbl_count == 0, "R1 reset count", tbl_count, 0);
        chk(!stop_overflow, "R1 reset overflow", stop_overflow, 0);
        chk(!pix_valid && pix_idx == 0, "R8 reset pixel", pix_idx, 0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            step(e[22], e[21], e[20], e[19], e[18:15], e[14:7]);
            chk(tbl_count == e[6:0], "R6 vector count", tbl_count, e[6:0]);
            compare_all();
        end
        // R9 read follows select within one step
        pix_sel = 3'd7; #1;
        chk(pix_idx == 3, "R9 p7 idx", pix_idx, 3);
        pix_sel = 3'd2; #1;
        chk(!pix_valid, "R5 p2 ignored", pix_valid, 0);

        // R1 priority: frame start with stop and hits
        step(1, 1, 0, 1, 4'h3, 8'hFF);
        chk(tbl_count == 0, "R1 frame beats stop", tbl_count, 0);
        step(0, 0, 0, 0, 4'h0, 8'hFF);
        compare_all();  // R1 window closed after frame start, hits ignored

        // R7 overflow
        step(1, 0, 0, 0, 4'h0, '0);
        for (int i = 0; i < 66; i++) step(0, 0, 0, 1, 4'(i % 16), '0);
        chk(tbl_count == 64, "R7 count held", tbl_count, 64);
        chk(stop_overflow, "R7 overflow set", stop_overflow, 1);
        tbl_addr = 6'd0; #1;
        chk(tbl_data == 0, "R7 entry0 unchanged", tbl_data, 0);
        tbl_addr = 6'd63; #1;
        chk(tbl_data == 15, "R7 entry63", tbl_data, 15);
        compare_all();
        step(0, 0, 0, 0, 4'h0, '0);
        chk(stop_overflow, "R7 overflow holds", stop_overflow, 1);
        step(1, 0, 0, 0, 4'h0, '0);
        chk(!stop_overflow && tbl_count == 0, "R1 overflow cleared", stop_overflow, 0);

        // R3 saturation
        for (int g = 0; g < 70; g++) begin
            step(0, 1, 0, 0, 4'h0, '0);
            step(0, 0, 1, 0, 4'h0, '0);
        end
        step(0, 1, 0, 0, 4'h0, '0);
        step(0, 0, 0, 0, 4'h0, 8'h04);
        pix_sel = 3'd2; #1;
        chk(pix_valid && pix_idx == 63, "R3 saturated idx", pix_idx, 63);
        pix_sel = 3'd3; #1;
        chk(!pix_valid && pix_idx == 0, "R8 no-hit pixel", pix_idx, 0);
        compare_all();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule